// File: doc/BRIEF.md
# Control-Register Bus Handshake Master

This block carries out indirect accesses to the 16-bit internal control registers of a PHY. The PHY offers a narrow strobe-and-acknowledge port. It has one shared 16-bit input bus, four separate strobes (capture address, capture data, commit write, launch read), a qualifier that marks the input bus as meaningful, an ack line and a 16-bit readback bus. Every access is built from phases. Each phase is a full four-phase handshake: raise a strobe, see ack high, drop the strobe, see ack low.

A host hands the engine one request at a time through a valid/ready handshake. A request is a read, a write or a read-modify-write, and it carries an address, write data and a mask. The engine answers with a single-cycle done pulse. For reads and read-modify-writes the pulse carries the read data. An error flag reports a handshake that never completed. The ack line is not watched on every cycle. It is checked once per poll interval, and a phase gives up after a fixed number of unanswered checks.

Top module: `crbus_master`

## Requirements
- R1: `req_ready_o` is high only while the engine is idle. A request is accepted on a cycle with `req_valid_i` and `req_ready_o` both high, and `req_ready_o` is low on the following cycle.
- R2: A read runs an address phase with the address on `phy_din_o`, then a read phase with `phy_din_o` equal to zero. The value on `phy_dout_i` at the ack check that sees ack high is returned on `rdata_o` with done.
- R3: A write runs an address phase, then a data-capture phase with the write data, then a write-commit phase. The same write data stays on `phy_din_o` throughout the commit phase.
- R4: A read-modify-write reads the target register and returns the old value on `rdata_o`. It then writes `(old & ~mask) | wdata` to the same address.
- R5: In every phase the strobe stays high until an ack check sees ack high. The strobe then drops, and the phase ends only when an ack check sees ack low. `phy_din_o` does not change while any strobe is high.
- R6: Before the address-capture or data-capture strobe rises, `phy_din_o` holds its value with `phy_din_vld_o` high for at least two cycles.
- R7: At most one strobe is high in any cycle. Bit positions: address capture, data capture, write commit, read launch. All strobes are low whenever the engine is idle.
- R8: Ack is checked once every `POLL_CYC` cycles of a wait, so with an immediate ack a strobe is high for exactly `POLL_CYC` cycles. After `TIMEOUT_CYC/POLL_CYC` checks with no answer, all strobes are low, done and `err_o` pulse together and the engine returns to idle.
- R9: `done_o` is high for exactly one cycle per request. `err_o` is low on a successful completion, and `rdata_o` is zero when a plain write completes.
- R10: The `req_op_i` encoding is 0 = read, 1 = write, 2 = read-modify-write. Code 3 behaves exactly as a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request offered |
| req_ready_o | output | 1 | Engine idle, request can be taken |
| req_op_i | input | 2 | Operation code |
| req_addr_i | input | DW | Target register address |
| req_wdata_i | input | DW | Write data / bits to OR in |
| req_mask_i | input | DW | Bits cleared before the OR (read-modify-write) |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Handshake timeout, valid with done |
| rdata_o | output | DW | Read data, valid with done |
| phy_din_o | output | DW | Shared address/data bus to the PHY |
| phy_din_vld_o | output | 1 | Qualifier for phy_din_o |
| phy_stb_addr_o | output | 1 | Address-capture strobe |
| phy_stb_data_o | output | 1 | Data-capture strobe |
| phy_stb_wr_o | output | 1 | Write-commit strobe |
| phy_stb_rd_o | output | 1 | Read-launch strobe |
| phy_ack_i | input | 1 | Acknowledge from the PHY |
| phy_dout_i | input | DW | Readback bus from the PHY |

## Verification
The bench builds the engine with `POLL_CYC` = 2 and `TIMEOUT_CYC` = 8. A wait therefore ends after four checks, and the exact strobe widths for an instant ack (2 cycles) and for no ack at all (8 cycles) are small numbers that can be measured. With these values a sweep over four ack latencies, every op code and a spread of addresses, data and masks stays short. The two failure modes also fit in a few cycles: a PHY that never raises ack and one that never drops it.

// File: rtl/crbus_pkg.sv
package crbus_pkg;

  // Host operation codes
  typedef enum logic [1:0] {
    CR_OP_READ  = 2'd0,
    CR_OP_WRITE = 2'd1,
    CR_OP_RMW   = 2'd2,
    CR_OP_READB = 2'd3
  } cr_op_e;

  // Phase kind; the value is also the strobe bit position
  typedef enum logic [1:0] {
    CR_K_ADDR  = 2'd0,
    CR_K_DATA  = 2'd1,
    CR_K_WRITE = 2'd2,
    CR_K_READ  = 2'd3
  } cr_kind_e;

  localparam int unsigned CR_NSTB = 4;

endpackage

// File: rtl/crbus_ack_poller.sv
module crbus_ack_poller #(
  parameter int unsigned POLL_CYC  = 2,
  parameter int unsigned MAX_POLLS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_i,   // a new wait starts next cycle
  input  logic run_i,   // currently waiting on ack
  output logic tick_o,  // sample ack this cycle
  output logic last_o   // this check is the final one allowed
);

  localparam int unsigned PW = (POLL_CYC > 1) ? $clog2(POLL_CYC) : 1;
  localparam int unsigned CW = (MAX_POLLS > 1) ? $clog2(MAX_POLLS) : 1;

  logic [PW-1:0] poll_q, poll_d;
  logic [CW-1:0] chk_q, chk_d;

  assign tick_o = run_i && (poll_q == PW'(POLL_CYC - 1));
  assign last_o = (chk_q == CW'(MAX_POLLS - 1));

  always_comb begin
    poll_d = poll_q;
    chk_d  = chk_q;
    if (arm_i) begin
      poll_d = '0;
      chk_d  = '0;
    end else if (run_i) begin
      if (tick_o) begin
        poll_d = '0;
        if (!last_o) chk_d = chk_q + 1'b1;
      end else begin
        poll_d = poll_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      poll_q <= '0;
      chk_q  <= '0;
    end else begin
      poll_q <= poll_d;
      chk_q  <= chk_d;
    end
  end

  generate
    if (POLL_CYC > 1) begin : g_gap
      p_tick_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);
    end
  endgenerate

endmodule

// File: rtl/crbus_phase.sv
module crbus_phase
  import crbus_pkg::*;
#(
  parameter int unsigned DW         = 16,
  parameter int unsigned SETUP_LONG = 2,
  parameter int unsigned POLL_CYC   = 2,
  parameter int unsigned MAX_POLLS  = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  cr_kind_e           kind_i,
  input  logic [DW-1:0]      din_i,
  input  logic               ack_i,
  input  logic [DW-1:0]      dout_i,
  output logic [CR_NSTB-1:0] stb_o,
  output logic [DW-1:0]      din_o,
  output logic               din_vld_o,
  output logic [DW-1:0]      rdata_o,
  output logic               done_o,
  output logic               fail_o
);

  localparam int unsigned SW = $clog2(SETUP_LONG + 1);

  typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_RISE, PH_FALL} ph_st_e;

  ph_st_e        st_q, st_d;
  cr_kind_e      kind_q, kind_d;
  logic [DW-1:0] din_q, din_d;
  logic [DW-1:0] rd_q, rd_d;
  logic [SW-1:0] cnt_q, cnt_d;
  logic          done_d, fail_d, done_q, fail_q;
  logic          arm, run, tick, last;

  assign run = (st_q == PH_RISE) || (st_q == PH_FALL);

  crbus_ack_poller #(.POLL_CYC(POLL_CYC), .MAX_POLLS(MAX_POLLS)) u_poll (
    .clk(clk), .rst_n(rst_n), .arm_i(arm), .run_i(run),
    .tick_o(tick), .last_o(last)
  );

  always_comb begin
    st_d   = st_q;
    kind_d = kind_q;
    din_d  = din_q;
    rd_d   = rd_q;
    cnt_d  = cnt_q;
    done_d = 1'b0;
    fail_d = 1'b0;
    arm    = 1'b0;
    case (st_q)
      PH_IDLE: if (start_i) begin
        st_d   = PH_SETUP;
        kind_d = kind_i;
        din_d  = din_i;
        cnt_d  = ((kind_i == CR_K_ADDR) || (kind_i == CR_K_DATA)) ?
                 SW'(SETUP_LONG - 1) : '0;
      end
      PH_SETUP: begin
        if (cnt_q == '0) begin
          st_d = PH_RISE;
          arm  = 1'b1;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      PH_RISE: if (tick) begin
        if (ack_i) begin
          st_d = PH_FALL;
          arm  = 1'b1;
          rd_d = dout_i;
        end else if (last) begin
          st_d   = PH_IDLE;
          fail_d = 1'b1;
        end
      end
      PH_FALL: if (tick) begin
        if (!ack_i) begin
          st_d   = PH_IDLE;
          done_d = 1'b1;
        end else if (last) begin
          st_d   = PH_IDLE;
          fail_d = 1'b1;
        end
      end
      default: st_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= PH_IDLE;
      kind_q <= CR_K_ADDR;
      din_q  <= '0;
      rd_q   <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
      fail_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      kind_q <= kind_d;
      din_q  <= din_d;
      rd_q   <= rd_d;
      cnt_q  <= cnt_d;
      done_q <= done_d;
      fail_q <= fail_d;
    end
  end

  assign stb_o     = (st_q == PH_RISE) ? (CR_NSTB'(1) << kind_q) : '0;
  assign din_o     = din_q;
  assign din_vld_o = (st_q != PH_IDLE);
  assign rdata_o   = rd_q;
  assign done_o    = done_q;
  assign fail_o    = fail_q;

  p_one_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(stb_o));

  p_din_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((|stb_o) && $past(|stb_o)) |-> $stable(din_o));

  p_setup_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(|stb_o) |-> $past(din_vld_o));

  p_end_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && fail_o));

endmodule

// File: rtl/crbus_master.sv
module crbus_master
  import crbus_pkg::*;
#(
  parameter int unsigned DW          = 16,
  parameter int unsigned SETUP_LONG  = 2,
  parameter int unsigned POLL_CYC    = 500,
  parameter int unsigned TIMEOUT_CYC = 100000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic [1:0]    req_op_i,
  input  logic [DW-1:0] req_addr_i,
  input  logic [DW-1:0] req_wdata_i,
  input  logic [DW-1:0] req_mask_i,
  output logic          done_o,
  output logic          err_o,
  output logic [DW-1:0] rdata_o,
  output logic [DW-1:0] phy_din_o,
  output logic          phy_din_vld_o,
  output logic          phy_stb_addr_o,
  output logic          phy_stb_data_o,
  output logic          phy_stb_wr_o,
  output logic          phy_stb_rd_o,
  input  logic          phy_ack_i,
  input  logic [DW-1:0] phy_dout_i
);

  localparam int unsigned MAX_POLLS =
    (TIMEOUT_CYC / POLL_CYC) > 0 ? (TIMEOUT_CYC / POLL_CYC) : 1;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_RADDR, SQ_READ, SQ_WADDR, SQ_WDATA, SQ_WRITE
  } sq_st_e;

  sq_st_e        sq_q, sq_d;
  logic [DW-1:0] addr_q, addr_d, wd_q, wd_d, mask_q, mask_d, rdat_q, rdat_d;
  logic          wr_q, wr_d, kick_q, kick_d, done_q, done_d, err_q, err_d;

  cr_kind_e      ph_kind;
  logic [DW-1:0] ph_din, ph_rdata;
  logic          ph_done, ph_fail;
  logic [CR_NSTB-1:0] stb;
  cr_op_e        op;

  assign op = cr_op_e'(req_op_i);

  // Phase parameters chosen by sequencer state
  always_comb begin
    ph_kind = CR_K_ADDR;
    ph_din  = addr_q;
    case (sq_q)
      SQ_READ:  begin ph_kind = CR_K_READ;  ph_din = '0;   end
      SQ_WDATA: begin ph_kind = CR_K_DATA;  ph_din = wd_q; end
      SQ_WRITE: begin ph_kind = CR_K_WRITE; ph_din = wd_q; end
      default:  begin ph_kind = CR_K_ADDR;  ph_din = addr_q; end
    endcase
  end

  always_comb begin
    sq_d   = sq_q;
    addr_d = addr_q;
    wd_d   = wd_q;
    mask_d = mask_q;
    rdat_d = rdat_q;
    wr_d   = wr_q;
    kick_d = 1'b0;
    done_d = 1'b0;
    err_d  = 1'b0;
    if (sq_q == SQ_IDLE) begin
      if (req_valid_i) begin
        addr_d = req_addr_i;
        wd_d   = req_wdata_i;
        mask_d = req_mask_i;
        rdat_d = '0;
        wr_d   = (op == CR_OP_WRITE) || (op == CR_OP_RMW);
        sq_d   = (op == CR_OP_WRITE) ? SQ_WADDR : SQ_RADDR;
        kick_d = 1'b1;
      end
    end else if (ph_fail) begin
      sq_d   = SQ_IDLE;
      done_d = 1'b1;
      err_d  = 1'b1;
    end else if (ph_done) begin
      case (sq_q)
        SQ_RADDR: begin sq_d = SQ_READ; kick_d = 1'b1; end
        SQ_READ: begin
          rdat_d = ph_rdata;
          if (wr_q) begin
            wd_d   = (ph_rdata & ~mask_q) | wd_q;
            sq_d   = SQ_WADDR;
            kick_d = 1'b1;
          end else begin
            sq_d   = SQ_IDLE;
            done_d = 1'b1;
          end
        end
        SQ_WADDR: begin sq_d = SQ_WDATA; kick_d = 1'b1; end
        SQ_WDATA: begin sq_d = SQ_WRITE; kick_d = 1'b1; end
        default: begin sq_d = SQ_IDLE; done_d = 1'b1; end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sq_q   <= SQ_IDLE;
      addr_q <= '0;
      wd_q   <= '0;
      mask_q <= '0;
      rdat_q <= '0;
      wr_q   <= 1'b0;
      kick_q <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      sq_q   <= sq_d;
      addr_q <= addr_d;
      wd_q   <= wd_d;
      mask_q <= mask_d;
      rdat_q <= rdat_d;
      wr_q   <= wr_d;
      kick_q <= kick_d;
      done_q <= done_d;
      err_q  <= err_d;
    end
  end

  crbus_phase #(
    .DW(DW), .SETUP_LONG(SETUP_LONG), .POLL_CYC(POLL_CYC), .MAX_POLLS(MAX_POLLS)
  ) u_phase (
    .clk(clk), .rst_n(rst_n), .start_i(kick_q), .kind_i(ph_kind), .din_i(ph_din),
    .ack_i(phy_ack_i), .dout_i(phy_dout_i), .stb_o(stb), .din_o(phy_din_o),
    .din_vld_o(phy_din_vld_o), .rdata_o(ph_rdata), .done_o(ph_done), .fail_o(ph_fail)
  );

  assign phy_stb_addr_o = stb[CR_K_ADDR];
  assign phy_stb_data_o = stb[CR_K_DATA];
  assign phy_stb_wr_o   = stb[CR_K_WRITE];
  assign phy_stb_rd_o   = stb[CR_K_READ];
  assign req_ready_o    = (sq_q == SQ_IDLE);
  assign done_o         = done_q;
  assign err_o          = err_q;
  assign rdata_o        = rdat_q;

  p_busy_after_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && req_ready_o) |=> !req_ready_o);

  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready_o |-> !(phy_stb_addr_o || phy_stb_data_o || phy_stb_wr_o || phy_stb_rd_o));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_err_with_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> (done_o && req_ready_o));

endmodule

// File: tb/crbus_master_tb.sv
`timescale 1ns/1ps
module crbus_master_tb;

  localparam int POLL = 2;
  localparam int TMO  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_op = 2'd0;
  logic [15:0] req_addr = '0, req_wdata = '0, req_mask = '0;
  logic        done, err;
  logic [15:0] rdata, din;
  logic        din_vld, s_a, s_d, s_w, s_r;
  logic        ack;
  logic [15:0] dout;

  crbus_master #(.DW(16), .SETUP_LONG(2), .POLL_CYC(POLL), .TIMEOUT_CYC(TMO)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_op_i(req_op), .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .req_mask_i(req_mask), .done_o(done), .err_o(err), .rdata_o(rdata),
    .phy_din_o(din), .phy_din_vld_o(din_vld), .phy_stb_addr_o(s_a),
    .phy_stb_data_o(s_d), .phy_stb_wr_o(s_w), .phy_stb_rd_o(s_r),
    .phy_ack_i(ack), .phy_dout_i(dout)
  );

  // ---------------- PHY model ----------------
  int          dly = 0;
  int          mode = 0;   // 0 normal, 1 never ack, 2 ack never drops
  int          hi_cnt, lo_cnt;
  logic [15:0] cap_addr, cap_data;
  logic [15:0] phy_mem [16];
  int          viol_wr_din;
  wire [3:0]   stbv = {s_r, s_w, s_d, s_a};

  function automatic logic [15:0] seed_val(int i);
    return 16'hA500 ^ 16'(i * 16'h0111);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack <= 1'b0; hi_cnt <= 0; lo_cnt <= 0;
      cap_addr <= '0; cap_data <= '0; dout <= 16'hDEAD; viol_wr_din <= 0;
      for (int i = 0; i < 16; i++) phy_mem[i] <= seed_val(i);
    end else if (|stbv) begin
      lo_cnt <= 0;
      if (!ack && mode != 1) begin
        if (hi_cnt >= dly) begin
          ack <= 1'b1;
          if (s_a) cap_addr <= din;
          if (s_d) cap_data <= din;
          if (s_w) begin
            phy_mem[cap_addr[3:0]] <= cap_data;
            if (din != cap_data) viol_wr_din <= viol_wr_din + 1;
          end
          if (s_r) dout <= phy_mem[cap_addr[3:0]];
        end else hi_cnt <= hi_cnt + 1;
      end
    end else begin
      hi_cnt <= 0;
      if (ack && mode != 2) begin
        if (lo_cnt >= dly) ack <= 1'b0;
        else lo_cnt <= lo_cnt + 1;
      end
    end
  end

  // ---------------- protocol monitor ----------------
  logic [3:0]  stb_prev = '0;
  logic [15:0] din_prev = '0;
  logic        vld_prev = 1'b0;
  int stable = 0, hi_w = 0, last_w = 0;
  int viol_onehot = 0, viol_hold = 0, viol_setup = 0, viol_idle = 0, viol_rdin = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if ($countones(stbv) > 1) viol_onehot++;
      if (req_ready && (|stbv)) viol_idle++;
      if ((|stbv) && (|stb_prev) && din != din_prev) viol_hold++;
      if (din_vld && vld_prev && din == din_prev) stable++;
      else stable = din_vld ? 1 : 0;
      if ((|stbv) && !(|stb_prev)) begin
        if ((s_a || s_d) && stable < 3) viol_setup++;
        if (s_r && din != 16'h0) viol_rdin++;
      end
      if (|stbv) hi_w++;
      else if (|stb_prev) begin last_w = hi_w; hi_w = 0; end
      stb_prev = stbv; din_prev = din; vld_prev = din_vld;
    end
  end

  // ---------------- bookkeeping ----------------
  int n_chk = 0, n_bad = 0, cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      $display("FAIL watchdog: run hung, actual cycles %0d expected < 150000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad + 1);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  logic [15:0] exp_mem [16];

  task automatic run_op(input logic [1:0] op, input logic [15:0] a, input logic [15:0] wd,
                        input logic [15:0] m, output logic [15:0] rd, output logic er);
    int guard;
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_addr = a; req_wdata = wd; req_mask = m;
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R1 busy after accept", 32'(req_ready), 0);
    guard = 0;
    while (!done && guard < 2000) begin @(negedge clk); guard++; end
    chk(done == 1'b1, "R9 done seen", 32'(done), 1);
    rd = rdata; er = err;
    @(negedge clk);
    chk(done == 1'b0, "R9 done one cycle", 32'(done), 0);
  endtask

  initial begin
    logic [15:0] rd, a, wd, m, old, nw;
    logic        er;
    for (int i = 0; i < 16; i++) exp_mem[i] = seed_val(i);
    repeat (3) @(negedge clk);
    // reset state
    chk(req_ready == 1'b1, "R1 ready after reset", 32'(req_ready), 1);
    chk(stbv == 4'h0 && done == 1'b0 && err == 1'b0, "R7 quiet after reset",
        32'({stbv, done, err}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // sweep: ack latency x op code x address/data/mask
    for (int d = 0; d < 4; d++) begin
      for (int k = 0; k < 8; k++) begin
        dly = d;
        a  = 16'h1000 | 16'(((k * 5) + (d * 3)) & 15);
        wd = 16'(16'h1234 * (k + 1)) ^ 16'(d);
        m  = 16'h00F0 << (k % 3);
        old = exp_mem[a[3:0]];
        run_op(2'(k % 4), a, wd, m, rd, er);
        chk(er == 1'b0, "R9 no error on success", 32'(er), 0);
        chk(cap_addr == a, "R2 address captured by PHY", 32'(cap_addr), 32'(a));
        case (k % 4)
          1: begin
            exp_mem[a[3:0]] = wd;
            chk(rd == 16'h0, "R9 write returns zero", 32'(rd), 0);
            chk(phy_mem[a[3:0]] == wd, "R3 write stored", 32'(phy_mem[a[3:0]]), 32'(wd));
          end
          2: begin
            nw = (old & ~m) | wd;
            exp_mem[a[3:0]] = nw;
            chk(rd == old, "R4 rmw returns old", 32'(rd), 32'(old));
            chk(phy_mem[a[3:0]] == nw, "R4 rmw merged write", 32'(phy_mem[a[3:0]]), 32'(nw));
          end
          3: chk(rd == old, "R10 code 3 reads", 32'(rd), 32'(old));
          default: chk(rd == old, "R2 read data", 32'(rd), 32'(old));
        endcase
        if (d == 0)
          chk(last_w == POLL, "R8 strobe width with instant ack", 32'(last_w), 32'(POLL));
      end
    end

    // a read after writes must observe the written value
    dly = 1;
    a = 16'h1000 | 16'd5;
    run_op(2'd0, a, 16'h0, 16'h0, rd, er);
    chk(rd == exp_mem[5], "R2 read back", 32'(rd), 32'(exp_mem[5]));

    // timeout with ack never rising
    mode = 1;
    run_op(2'd1, 16'h1003, 16'hBEEF, 16'h0, rd, er);
    chk(er == 1'b1, "R8 timeout error on missing ack", 32'(er), 1);
    chk(last_w == TMO, "R8 strobe held for the whole timeout", 32'(last_w), 32'(TMO));
    chk(stbv == 4'h0 && req_ready == 1'b1, "R8 idle and quiet after timeout",
        32'({stbv, req_ready}), 1);
    chk(phy_mem[3] == exp_mem[3], "R8 aborted write leaves register", 32'(phy_mem[3]), 32'(exp_mem[3]));

    // timeout with ack never dropping
    mode = 2; dly = 0;
    run_op(2'd0, 16'h1007, 16'h0, 16'h0, rd, er);
    chk(er == 1'b1, "R8 timeout error on stuck ack", 32'(er), 1);
    chk(stbv == 4'h0, "R8 strobes low after stuck ack", 32'(stbv), 0);
    mode = 0;
    repeat (4) @(negedge clk);

    // engine recovers
    run_op(2'd2, 16'h1009, 16'h000A, 16'h000F, rd, er);
    chk(er == 1'b0 && rd == exp_mem[9], "R4 rmw after recovery", 32'(rd), 32'(exp_mem[9]));
    exp_mem[9] = (exp_mem[9] & ~16'h000F) | 16'h000A;
    chk(phy_mem[9] == exp_mem[9], "R4 rmw after recovery stored", 32'(phy_mem[9]), 32'(exp_mem[9]));

    // protocol monitor totals
    chk(viol_hold == 0, "R5 din stable while strobe high", 32'(viol_hold), 0);
    chk(viol_setup == 0, "R6 setup before capture strobes", 32'(viol_setup), 0);
    chk(viol_onehot == 0, "R7 single strobe", 32'(viol_onehot), 0);
    chk(viol_idle == 0, "R7 strobes low in idle", 32'(viol_idle), 0);
    chk(viol_rdin == 0, "R2 din zero on read strobe", 32'(viol_rdin), 0);
    chk(viol_wr_din == 0, "R3 write data held on commit", 32'(viol_wr_din), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule